// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block decides which of four bus masters owns a shared system bus: the processor, a DMA engine, a DRAM refresh engine and an off-chip master that asks for the bus through a hold request/acknowledge pair. The processor and refresh engine each appear twice in a six-level fixed ranking. The processor ranks at the top while its bus-lock flag is set and otherwise near the bottom. Refresh ranks second when it is urgent and last when it is not, so an idle-time refresh only runs on an otherwise quiet bus.

On-chip masters keep the bus until the owner signals the end of its current cycle. Ownership then passes to the best pending requester on the next clock. The off-chip master cannot be stopped in mid-cycle. When a request that outranks it appears, the arbiter drops the hold acknowledge and waits (the bus wait) until the off-chip master lowers its hold request. Only then does it grant the bus to the on-chip winner.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, every grant output and the hold acknowledge are low.
- R2: At no clock are two of `cpu_gnt`, `dma_gnt`, `ref_gnt`, `hold_ack` high together.
- R3: From an idle bus, the next clock grants the highest pending request in this ranking: processor with lock flag, urgent refresh (`ref_req` and `ref_urgent`), DMA, off-chip hold, processor without lock, non-urgent refresh.
- R4: While an on-chip master owns the bus and `cycle_done` is low, its grant stays high and no other grant changes.
- R5: When `cycle_done` is high during on-chip ownership and the winner is an on-chip master, that master is granted on the next clock, with no idle cycle between. The same master may be granted again. With no request, all grants go low.
- R6: When an on-chip cycle ends and the off-chip hold request is the winner, all grants are low for one clock and `hold_ack` rises on the clock after.
- R7: While `hold_ack` and `hold_req` are high, a pending locked processor request, urgent refresh or DMA request lowers `hold_ack` on the next clock. A non-urgent refresh or an unlocked processor request leaves it high.
- R8: After `hold_ack` has been withdrawn, no grant is given while `hold_req` stays high. The clock after `hold_req` is seen low, the best pending on-chip request is granted.
- R9: If the off-chip master lowers `hold_req` while acknowledged, `hold_ack` falls on the next clock and the best on-chip request is granted on that same clock.
- R10: While `cpu_lock` is high, no master other than the processor gains a grant, including an urgent refresh. If the processor does not request, the bus stays idle.
- R11: Urgent refresh outranks DMA. Non-urgent refresh is granted only when no other request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor wants the bus |
| cpu_lock | input | 1 | Processor bus-lock flag |
| dma_req | input | 1 | DMA engine wants the bus |
| ref_req | input | 1 | Refresh engine wants the bus |
| ref_urgent | input | 1 | Refresh backlog is critical; raises refresh rank |
| hold_req | input | 1 | Off-chip master hold request |
| cycle_done | input | 1 | Current on-chip bus cycle ends this clock |
| cpu_gnt | output | 1 | Bus granted to processor |
| dma_gnt | output | 1 | Bus granted to DMA engine |
| ref_gnt | output | 1 | Bus granted to refresh engine |
| hold_ack | output | 1 | Bus handed to off-chip master |

## Verification
The hardest state to reach is the bus wait. The off-chip master has to be acknowledged first, then keep its hold request high while an outranking on-chip request arrives. Only after that may the hold request drop. The bench walks through this order with directed steps. It then runs a long random phase in which the hold request is sticky and changes only rarely. Short on-chip requests therefore keep landing inside off-chip ownership. A behavioural reference model is compared with every output on every clock.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Number of ranked request levels and the slot of the off-chip hold level.
  localparam int unsigned NUM_LEVELS = 6;
  localparam int unsigned NUM_GNTS   = 4;
  localparam int unsigned LVL_LOCK   = 0;
  localparam int unsigned LVL_URGREF = 1;
  localparam int unsigned LVL_DMA    = 2;
  localparam int unsigned LVL_HOLD   = 3;
  localparam int unsigned LVL_CPU    = 4;
  localparam int unsigned LVL_IDLREF = 5;

  typedef enum logic [2:0] {
    OWN_IDLE = 3'd0,
    OWN_CPU  = 3'd1,
    OWN_DMA  = 3'd2,
    OWN_REF  = 3'd3,
    OWN_EXT  = 3'd4,
    OWN_WAIT = 3'd5
  } owner_e;

  // Which master a ranked level stands for.
  function automatic owner_e level_owner(input int unsigned idx);
    owner_e o;
    case (idx)
      LVL_LOCK, LVL_CPU:      o = OWN_CPU;
      LVL_URGREF, LVL_IDLREF: o = OWN_REF;
      LVL_DMA:                o = OWN_DMA;
      LVL_HOLD:               o = OWN_EXT;
      default:                o = OWN_IDLE;
    endcase
    return o;
  endfunction

  // Grant vector {ext, ref, dma, cpu} for an owner state.
  function automatic logic [NUM_GNTS-1:0] owner_grants(input owner_e o);
    logic [NUM_GNTS-1:0] g;
    case (o)
      OWN_CPU: g = 4'b0001;
      OWN_DMA: g = 4'b0010;
      OWN_REF: g = 4'b0100;
      OWN_EXT: g = 4'b1000;
      default: g = 4'b0000;
    endcase
    return g;
  endfunction

  function automatic logic is_internal(input owner_e o);
    return (o == OWN_CPU) || (o == OWN_DMA) || (o == OWN_REF);
  endfunction

endpackage

// File: rtl/arb_level_rank.sv
module arb_level_rank
  import bus_arb_pkg::*;
(
  input  logic                  cpu_req,
  input  logic                  cpu_lock,
  input  logic                  dma_req,
  input  logic                  ref_req,
  input  logic                  ref_urgent,
  input  logic                  hold_req,
  output logic [NUM_LEVELS-1:0] level_vec,
  output logic                  preempt_ext
);

  // A set lock flag masks every level except the locked processor.
  logic open_bus;
  assign open_bus = ~cpu_lock;

  always_comb begin
    level_vec             = '0;
    level_vec[LVL_LOCK]   = cpu_req & cpu_lock;
    level_vec[LVL_URGREF] = open_bus & ref_req & ref_urgent;
    level_vec[LVL_DMA]    = open_bus & dma_req;
    level_vec[LVL_HOLD]   = open_bus & hold_req;
    level_vec[LVL_CPU]    = open_bus & cpu_req;
    level_vec[LVL_IDLREF] = open_bus & ref_req & ~ref_urgent;
  end

  // Any level ranked above the hold level reclaims the bus from the off-chip master.
  assign preempt_ext = |level_vec[LVL_HOLD-1:0];

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] first
);

  logic [N-1:0] higher_set;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign higher_set[i] = 1'b0;
      end else begin : g_rest
        assign higher_set[i] = higher_set[i-1] | req[i-1];
      end
      assign first[i] = req[i] & ~higher_set[i];
    end
  endgenerate

  // R3
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first) && ((|req) == (|first)));

endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import bus_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cycle_done,
  input  logic   hold_req,
  input  logic   preempt_ext,
  input  owner_e win,
  output owner_e owner,
  output logic   bus_wait
);

  owner_e nxt;

  always_comb begin
    nxt = owner;
    case (owner)
      OWN_IDLE: nxt = win;
      OWN_CPU, OWN_DMA, OWN_REF: begin
        if (cycle_done) nxt = (win == OWN_EXT) ? OWN_IDLE : win;
      end
      OWN_EXT: begin
        if (!hold_req)        nxt = win;
        else if (preempt_ext) nxt = OWN_WAIT;
      end
      OWN_WAIT: begin
        if (!hold_req) nxt = win;
      end
      default: nxt = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner <= OWN_IDLE;
    else        owner <= nxt;
  end

  assign bus_wait = (owner == OWN_WAIT);

  // R4
  int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_internal(owner) && !cycle_done) |=> $stable(owner));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wait && hold_req) |=> bus_wait);

  // R6
  ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner == OWN_EXT) |-> $past(owner == OWN_IDLE));

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_lock,
  input  logic dma_req,
  input  logic ref_req,
  input  logic ref_urgent,
  input  logic hold_req,
  input  logic cycle_done,
  output logic cpu_gnt,
  output logic dma_gnt,
  output logic ref_gnt,
  output logic hold_ack
);

  logic [NUM_LEVELS-1:0] level_vec;
  logic [NUM_LEVELS-1:0] level_first;
  logic                  preempt_ext;
  owner_e                win;
  owner_e                owner;
  logic                  bus_wait;
  logic [NUM_GNTS-1:0]   gnt_vec;

  arb_level_rank u_rank (
    .cpu_req     (cpu_req),
    .cpu_lock    (cpu_lock),
    .dma_req     (dma_req),
    .ref_req     (ref_req),
    .ref_urgent  (ref_urgent),
    .hold_req    (hold_req),
    .level_vec   (level_vec),
    .preempt_ext (preempt_ext)
  );

  arb_prio_pick #(.N(NUM_LEVELS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (level_vec),
    .first (level_first)
  );

  always_comb begin
    win = OWN_IDLE;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level_first[i]) win = level_owner(i);
    end
  end

  arb_owner_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_done  (cycle_done),
    .hold_req    (hold_req),
    .preempt_ext (preempt_ext),
    .win         (win),
    .owner       (owner),
    .bus_wait    (bus_wait)
  );

  assign gnt_vec  = owner_grants(owner);
  assign cpu_gnt  = gnt_vec[0];
  assign dma_gnt  = gnt_vec[1];
  assign ref_gnt  = gnt_vec[2];
  assign hold_ack = gnt_vec[3];

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt, ref_gnt, hold_ack}));

  // R10
  lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lock |=> !($rose(dma_gnt) || $rose(ref_gnt) || $rose(hold_ack)));

  // R7
  ext_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && hold_req &&
     ((cpu_req && cpu_lock) || (!cpu_lock && (dma_req || (ref_req && ref_urgent)))))
    |=> !hold_ack);

  // R9
  ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  // R8
  no_gnt_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> !(cpu_gnt || dma_gnt || ref_gnt || hold_ack));

endmodule

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_lock = 0, dma_req = 0, ref_req = 0, ref_urgent = 0;
  logic hold_req = 0, cycle_done = 0;
  logic cpu_gnt, dma_gnt, ref_gnt, hold_ack;

  int errors = 0;
  int checks = 0;
  int m_own = 0;  // 0 idle, 1 cpu, 2 dma, 3 refresh, 4 off-chip, 5 waiting

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter u_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_lock(cpu_lock),
    .dma_req(dma_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .hold_req(hold_req), .cycle_done(cycle_done),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .ref_gnt(ref_gnt), .hold_ack(hold_ack)
  );

  function automatic int best_pending();
    if (cpu_lock) return cpu_req ? 1 : 0;
    if (ref_req && ref_urgent) return 3;
    if (dma_req) return 2;
    if (hold_req) return 4;
    if (cpu_req) return 1;
    if (ref_req) return 3;
    return 0;
  endfunction

  function automatic logic [3:0] model_vec(input int o);
    if (o == 1) return 4'b0001;
    if (o == 2) return 4'b0010;
    if (o == 3) return 4'b0100;
    if (o == 4) return 4'b1000;
    return 4'b0000;
  endfunction

  // Reference model of ownership, updated on each rising edge.
  always @(posedge clk) begin
    int w;
    w = best_pending();
    if (!rst_n) m_own <= 0;
    else if (m_own == 0) m_own <= w;
    else if (m_own >= 1 && m_own <= 3) begin
      if (cycle_done) m_own <= (w == 4) ? 0 : w;
    end else if (m_own == 4) begin
      if (!hold_req) m_own <= w;
      else if ((cpu_req && cpu_lock) || (!cpu_lock && (dma_req || (ref_req && ref_urgent))))
        m_own <= 5;
    end else begin
      if (!hold_req) m_own <= w;
    end
  end

  wire [3:0] gv = {hold_ack, ref_gnt, dma_gnt, cpu_gnt};

  // Every clock: one-hot grants and agreement with the model.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (!$onehot0(gv)) begin
        errors++;
        $display("FAIL R2 onehot: actual=%b expected=at most one bit", gv);
      end
      checks++;
      if (gv !== model_vec(m_own)) begin
        errors++;
        $display("FAIL R5 model compare at %0t: actual=%b expected=%b", $time, gv, model_vec(m_own));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if (gv !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, gv, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", 4'b0000);

    // Grant vector bits: {ext, ref, dma, cpu}.
    cpu_req = 1; dma_req = 1; ref_req = 1;
    step(); chk("R3 dma above cpu and idle refresh", 4'b0010);
    ref_urgent = 1;
    step(); chk("R4 dma kept without cycle_done", 4'b0010);
    step(); chk("R4 dma kept again", 4'b0010);
    cycle_done = 1;
    step(); chk("R11 urgent refresh above dma", 4'b0100);
    ref_req = 0; ref_urgent = 0;
    step(); chk("R5 dma back at boundary", 4'b0010);
    dma_req = 0;
    step(); chk("R5 cpu at boundary", 4'b0001);
    cpu_req = 0; ref_req = 1;
    step(); chk("R11 idle refresh on quiet bus", 4'b0100);
    cpu_req = 1;
    step(); chk("R3 cpu above idle refresh", 4'b0001);
    hold_req = 1;
    step(); chk("R6 free cycle before hold_ack", 4'b0000);
    cycle_done = 0;
    step(); chk("R6 hold_ack one clock after free", 4'b1000);
    step(); chk("R7 low levels keep hold_ack", 4'b1000);
    step(); chk("R7 low levels keep hold_ack again", 4'b1000);
    dma_req = 1;
    step(); chk("R7 dma withdraws hold_ack", 4'b0000);
    step(); chk("R8 bus wait holds", 4'b0000);
    step(); chk("R8 bus wait holds again", 4'b0000);
    hold_req = 0;
    step(); chk("R8 dma after hold drops", 4'b0010);
    dma_req = 0; cpu_req = 0; ref_req = 0; hold_req = 1; cycle_done = 1;
    step(); chk("R6 free cycle after dma", 4'b0000);
    cycle_done = 0;
    step(); chk("R6 hold_ack granted", 4'b1000);
    hold_req = 0; cpu_req = 1;
    step(); chk("R9 release hands bus to cpu", 4'b0001);
    cpu_lock = 1; dma_req = 1; ref_req = 1; ref_urgent = 1; hold_req = 1; cycle_done = 1;
    step(); chk("R10 locked cpu beats urgent refresh", 4'b0001);
    cpu_req = 0;
    step(); chk("R10 lock keeps bus idle", 4'b0000);
    step(); chk("R10 lock keeps bus idle again", 4'b0000);
    cpu_lock = 0;
    step(); chk("R3 urgent refresh after unlock", 4'b0100);

    // Random phase; the hold request is sticky so bus waits occur often.
    for (int n = 0; n < 4000; n++) begin
      cpu_req    = ($urandom % 3) == 0;
      cpu_lock   = ($urandom % 6) == 0;
      dma_req    = ($urandom % 5) == 0;
      ref_req    = ($urandom % 4) == 0;
      ref_urgent = ($urandom % 3) == 0;
      cycle_done = ($urandom % 2) == 0;
      if (($urandom % 10) == 0) hold_req = ~hold_req;
      step();
    end
    finish_run();
  end

endmodule